// File: doc/BRIEF.md
# Multi-Lane Read Response Dispatcher

This block sits on the outbound side of a serial register link. Read responses and register auto-read events enter a 16-entry queue. The block then sends them as 32-bit frames over three parallel data lanes. All lanes share one bit-clock enable and one frame-sync output. Frame slots are aligned across the lanes. At each slot boundary the block takes up to three entries from the queue in arrival order. The oldest entry goes on lane 0, the next on lane 1 and the third on lane 2. A lane with no entry sends an all-zero frame, which marks it empty.

Each frame carries a 4-bit rank. The block keeps one rank counter per address, so when one source is read several times the receiver can put the responses back in order. A register auto-read event counts as a read response in every way. It gets a rank and a queue slot, and it is sent the same way. If the queue is full, a new entry is dropped and a sticky overflow flag is set.

Top module: `rsp_lane_dispatch`

## Requirements
- R1: Each frame is 32 bits: bit 31 is the valid flag, bit 30 is the write flag, bits 29:26 are the rank, bits 25:16 are the address and bits 15:0 are the data.
- R2: Frames are sent MSB first, one bit per bit period, and all lanes share the same slot timing. The frame sync is high for exactly one bit period, the period that carries bit 0 of the previous slot, just before each MSB.
- R3: At a slot boundary the block sends k = min(queue occupancy, 3) entries. They go on lanes 0 to k-1, so the valid lanes always form a run that starts at lane 0.
- R4: Entries leave in the order they were accepted. Within one slot, lane order follows queue order. Across slots, every lane of an earlier slot comes before any lane of a later slot.
- R5: A lane with no entry in a slot sends a frame of all zeros, so its valid flag is 0.
- R6: The write flag of every outbound frame is 0.
- R7: An accepted entry takes its address's rank counter as its rank, and the counter then steps by one, modulo 16. A dropped entry leaves the counter unchanged. Every counter is 0 after reset.
- R8: An auto-read push is queued and ranked exactly like a read response. If both arrive in the same cycle, the read response is queued first. When both use the same address, the auto-read entry takes the next rank.
- R9: The queue holds 16 entries, and a push is accepted only when the queue has room. The occupancy used is the value before any pop in the same cycle, plus any push accepted earlier in that cycle. A dropped push sets the overflow output, which stays high until reset.
- R10: During reset the frame sync is high and all lanes, the overflow output and the bit-clock enable are low. The first slot after reset is empty on every lane.
- R11: The bit-clock enable is high for one cycle out of every DIV system cycles (DIV = 2 by default). Outputs change only on the cycle where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read response push strobe |
| rd_addr | input | 10 | Address of the read response |
| rd_data | input | 16 | Data of the read response |
| auto_valid | input | 1 | Auto-read push strobe (the watched register was updated) |
| auto_addr | input | 10 | Address of the auto-read register |
| auto_data | input | 16 | New value of the auto-read register |
| ser_clk_en | output | 1 | Bit-clock enable, high on the last cycle of each bit period |
| ser_frm | output | 1 | Frame sync, high during the bit period before each MSB |
| ser_dat | output | 3 | Serial data, one bit per lane |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that:
- the occupancy never goes above the queue depth;
- a push into a full queue raises the overflow flag, and the flag stays high;
- the frame sync lasts one bit period;
- freshly loaded lanes form a run of valid frames starting at lane 0, with the write flag cleared;
- enable pulses never come on consecutive cycles.

Only the bench's scenarios can show the rest. It decodes the lanes the way a receiver would and compares each frame with an arithmetic model. This covers FIFO order across lanes and slots, the per-address ranks and their wrap, read-before-auto ordering, and the exact number of entries sent in each slot as burst size changes. It also covers which entries are dropped and that their ranks are not consumed.

// File: rtl/rsp_lane_dispatch.sv
module rsp_lane_dispatch #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int LANES  = 3,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              auto_valid,
  input  logic [ADDR_W-1:0] auto_addr,
  input  logic [DATA_W-1:0] auto_data,
  output logic              ser_clk_en,
  output logic              ser_frm,
  output logic [LANES-1:0]  ser_dat,
  output logic              ovf
);
  localparam int RANK_W  = 4;
  localparam int ENT_W   = RANK_W + ADDR_W + DATA_W;
  localparam int FRAME_W = 2 + ENT_W;
  localparam int PW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int BW      = $clog2(FRAME_W);
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NADDR   = 1 << ADDR_W;

  logic [ENT_W-1:0]   mem [DEPTH];
  logic [RANK_W-1:0]  rank_tbl [NADDR];
  logic [FRAME_W-1:0] sh [LANES];
  logic [PW-1:0]      wr_ptr, rd_ptr;
  logic [CW-1:0]      occ, npop, occ_mid;
  logic [DW-1:0]      dc;
  logic [BW-1:0]      bitc;
  logic [LANES-1:0]   vb, wb;
  logic [RANK_W-1:0]  rk_rd, rk_au;
  logic               tick, load, acc_rd, acc_au;

  generate
    if (DIV > 1) begin : g_div
      assign tick = (dc == DW'(DIV - 1));
      always_ff @(posedge clk)
        if (!rst_n) dc <= '0;
        else        dc <= tick ? '0 : dc + 1'b1;
      AST_CLKEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
    end else begin : g_nodiv
      assign tick = 1'b1;
      always_ff @(posedge clk) dc <= '0;
    end
  endgenerate

  assign ser_clk_en = tick;
  assign ser_frm    = (bitc == '0);
  assign load       = tick && ser_frm;
  assign npop       = (occ >= CW'(LANES)) ? CW'(LANES) : occ;

  assign acc_rd  = rd_valid && (occ < CW'(DEPTH));
  assign occ_mid = occ + CW'(acc_rd);
  assign acc_au  = auto_valid && (occ_mid < CW'(DEPTH));
  assign rk_rd   = rank_tbl[rd_addr];
  assign rk_au   = rank_tbl[auto_addr] + RANK_W'(acc_rd && (rd_addr == auto_addr));

  always_ff @(posedge clk) begin
    if (acc_rd) mem[wr_ptr] <= {rk_rd, rd_addr, rd_data};
    if (acc_au) mem[wr_ptr + PW'(acc_rd)] <= {rk_au, auto_addr, auto_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
      bitc   <= '0;
      for (int i = 0; i < NADDR; i++) rank_tbl[i] <= '0;
      for (int l = 0; l < LANES; l++) sh[l] <= '0;
    end else begin
      if (acc_rd) rank_tbl[rd_addr]   <= rk_rd + 1'b1;
      if (acc_au) rank_tbl[auto_addr] <= rk_au + 1'b1;
      wr_ptr <= wr_ptr + PW'(acc_rd) + PW'(acc_au);
      occ    <= occ - (load ? npop : '0) + CW'(acc_rd) + CW'(acc_au);
      if (load) rd_ptr <= rd_ptr + PW'(npop);
      if ((rd_valid && !acc_rd) || (auto_valid && !acc_au)) ovf <= 1'b1;
      if (tick) bitc <= ser_frm ? BW'(FRAME_W - 1) : bitc - 1'b1;
      for (int l = 0; l < LANES; l++) begin
        if (load)
          sh[l] <= (CW'(l) < npop) ? {1'b1, 1'b0, mem[rd_ptr + PW'(l)]} : '0;
        else if (tick)
          sh[l] <= sh[l] << 1;
      end
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign ser_dat[l] = sh[l][FRAME_W-1];
      assign vb[l]      = sh[l][FRAME_W-1];
      assign wb[l]      = sh[l][FRAME_W-2];
    end
  endgenerate

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R9
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && occ == CW'(DEPTH)) |=> ovf); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
  AST_FRM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ser_frm) |=> !ser_frm); // R2
  AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((vb & (vb + 1'b1)) == '0)); // R3
  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wb == '0)); // R6
endmodule

// File: tb/test_rsp_lane_dispatch.sv
module test_rsp_lane_dispatch;
  localparam int LANES = 3;
  localparam int DEPTH = 16;
  localparam int DIV   = 2;
  localparam int FW    = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 1'b0, auto_valid = 1'b0;
  logic [9:0] rd_addr = '0, auto_addr = '0;
  logic [15:0] rd_data = '0, auto_data = '0;
  logic ser_clk_en, ser_frm, ovf;
  logic [LANES-1:0] ser_dat;

  rsp_lane_dispatch i_rsp_lane_dispatch (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .auto_valid(auto_valid), .auto_addr(auto_addr), .auto_data(auto_data),
    .ser_clk_en(ser_clk_en), .ser_frm(ser_frm), .ser_dat(ser_dat), .ovf(ovf)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int rk [1024];
  logic [31:0] q[$];
  logic [31:0] slots[$];
  logic [31:0] rx [LANES];
  int nb = 0, since_en = 0;
  bit in_fr = 0, bad_frm = 0, seen_en = 0, model_ovf = 0, done = 0;
  string cur = "R5";

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (scenario %s) got %h exp %h", tag, cur, got, exp);
    end
  endtask

  task automatic slot_done();
    logic [LANES-1:0] v;
    logic [31:0] e;
    string tag;
    chk(!bad_frm && ser_frm, "R2 frame sync placement", {31'd0, bad_frm}, 32'd0);
    for (int l = 0; l < LANES; l++) v[l] = rx[l][31];
    chk((v & (v + 1'b1)) == '0, "R3 valid lanes start at lane 0", {29'd0, v}, 32'd0);
    for (int l = 0; l < LANES; l++) begin
      e = (slots.size() > 0) ? slots.pop_front() : 32'hDEAD_BEEF;
      if (e[31] == 1'b0)              tag = "R5 idle lane";
      else if (rx[l][31] != e[31])    tag = "R3 lane fill";
      else if (rx[l][30] != 1'b0)     tag = "R6 write flag";
      else if (rx[l][29:26] != e[29:26]) tag = "R7 rank";
      else                            tag = "R1/R4 layout and order";
      chk(rx[l] == e, tag, rx[l], e);
    end
  endtask

  // receiver decode and reference model, both evaluated away from the active edge
  always @(negedge clk) if (rst_n) begin
    int occ0, cnt, n;
    since_en++;
    occ0 = q.size();
    if (ser_clk_en) begin
      if (seen_en) chk(since_en == DIV, "R11 enable spacing", since_en, DIV);
      seen_en = 1; since_en = 0;
      if (in_fr) begin
        for (int l = 0; l < LANES; l++) rx[l] = {rx[l][30:0], ser_dat[l]};
        nb++;
        if (ser_frm && nb != FW) bad_frm = 1;
        if (nb == FW) begin slot_done(); in_fr = 0; end
      end else if (!ser_frm) bad_frm = 1;
      if (ser_frm) begin
        in_fr = 1; nb = 0; bad_frm = 0;
        n = (occ0 < LANES) ? occ0 : LANES;
        for (int l = 0; l < LANES; l++) slots.push_back(l < n ? q.pop_front() : 32'd0);
      end
    end
    cnt = occ0;
    if (rd_valid) begin
      if (cnt < DEPTH) begin
        q.push_back({1'b1, 1'b0, 4'(rk[rd_addr]), rd_addr, rd_data});
        rk[rd_addr] = (rk[rd_addr] + 1) % 16;
        cnt++;
      end else model_ovf = 1;
    end
    if (auto_valid) begin
      if (cnt < DEPTH) begin
        q.push_back({1'b1, 1'b0, 4'(rk[auto_addr]), auto_addr, auto_data});
        rk[auto_addr] = (rk[auto_addr] + 1) % 16;
      end else model_ovf = 1;
    end
  end

  task automatic push(input bit rv, input logic [9:0] ra, input logic [15:0] rdt,
                      input bit av, input logic [9:0] aa, input logic [15:0] adt);
    rd_valid = rv; rd_addr = ra; rd_data = rdt;
    auto_valid = av; auto_addr = aa; auto_data = adt;
    @(posedge clk); #2;
    rd_valid = 1'b0; auto_valid = 1'b0;
  endtask

  task automatic wait_bound(input int k);
    for (int j = 0; j < k; j++) begin
      do @(negedge clk); while (!(ser_frm && ser_clk_en));
    end
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) rk[a] = 0;
    repeat (4) @(posedge clk); #2;
    // R10 reset state
    chk(ser_frm == 1'b1, "R10 frame sync in reset", {31'd0, ser_frm}, 32'd1);
    chk(ser_dat == '0, "R10 lanes low in reset", {29'd0, ser_dat}, 32'd0);
    chk(ovf == 1'b0, "R10 overflow low in reset", {31'd0, ovf}, 32'd0);
    chk(ser_clk_en == 1'b0, "R10 enable low in reset", {31'd0, ser_clk_en}, 32'd0);
    rst_n = 1'b1;
    cur = "R5"; wait_bound(3);
    // burst sizes 1..7 with repeated addresses (R3, R4, R7)
    cur = "R3";
    for (int n = 1; n <= 7; n++) begin
      wait_bound(1);
      for (int i = 0; i < n; i++) push(1, 10'((i % 3) + n % 2), 16'(n * 256 + i), 0, '0, '0);
      wait_bound(4);
    end
    // rank wrap on one address: 20 entries over several bursts (R7)
    cur = "R7";
    for (int b = 0; b < 4; b++) begin
      wait_bound(1);
      for (int i = 0; i < 5; i++) push(1, 10'h3FF, 16'(b * 16 + i), 0, '0, '0);
    end
    wait_bound(4);
    // auto-read pushes alone and together with reads (R8)
    cur = "R8";
    wait_bound(1);
    push(0, '0, '0, 1, 10'h055, 16'hA001);
    push(0, '0, '0, 1, 10'h055, 16'hA002);
    push(1, 10'h055, 16'hB001, 1, 10'h055, 16'hA003);
    push(1, 10'h056, 16'hB002, 1, 10'h057, 16'hA004);
    push(1, 10'h055, 16'hB003, 1, 10'h055, 16'hA005);
    wait_bound(5);
    // overflow: 20 back-to-back reads, then a pair at the full edge (R9)
    cur = "R9";
    chk(ovf == 1'b0, "R9 no overflow yet", {31'd0, ovf}, 32'd0);
    wait_bound(1);
    for (int i = 0; i < 20; i++) push(1, 10'(i % 5), 16'(16'hC000 + i), 0, '0, '0);
    wait_bound(8);
    chk(ovf == model_ovf && ovf, "R9 overflow set", {31'd0, ovf}, 32'd1);
    wait_bound(1);
    for (int i = 0; i < 15; i++) push(1, 10'h010, 16'(16'hD000 + i), 0, '0, '0);
    push(1, 10'h011, 16'hD100, 1, 10'h011, 16'hD101);
    push(0, '0, '0, 1, 10'h011, 16'hD102);
    wait_bound(8);
    push(0, '0, '0, 1, 10'h011, 16'hD103);
    push(1, 10'h000, 16'hD104, 0, '0, '0);
    wait_bound(4);
    chk(ovf == 1'b1, "R9 overflow sticky", {31'd0, ovf}, 32'd1);
    chk(q.size() == 0, "R4 queue drained", q.size(), 32'd0);
    wait_bound(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got %h exp %h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end
endmodule